// File: doc/BRIEF.md
# Keypad Digit Encoder and Serializer

The block watches ten active-low digit keys, one for each of the values 0 through 9. It turns the pressed key into its 4-bit binary value and raises a flag while any digit key is down. Both of these outputs are combinational, so a scan block or another reader can sample them at any time.

The binary value also goes out on one serial line. A separate scan block asserts `slot_start` for one clock at the first clock of the key digit's 4-clock slot within the digit-serial frame. On that edge the block latches the current code. It then presents the code least-significant bit first, one bit per clock, over the four clocks that follow. Outside those four bits, and after a slot in which no key was down, the serial line stays at zero. A 4-bit group is never split across two slots, because a capture happens only on a slot-start edge.

Top module: `keypad_digit_serializer`

## Requirements
- R1: Key input `key_n[k]` is low while key k is pressed. With only key k pressed, `key_code` equals k in plain binary (bit 0 has weight 1, bit 3 has weight 8).
- R2: When several keys are pressed together, `key_code` reports the highest-numbered pressed key.
- R3: `key_any` is 1 exactly when at least one `key_n` bit is low. When no key is pressed, `key_code` is 0.
- R4: The code is captured only on a rising clock edge at which `slot_start` is 1. Key activity between slot starts leaves `ser_out` at 0.
- R5: After a capture edge with a key down, `ser_out` shows code bit 0 in the following clock cycle, then bits 1, 2 and 3 in the next three cycles.
- R6: The captured code is held for the whole 4-bit group. Changing or releasing keys after the capture does not alter the bits still to be sent.
- R7: `ser_out` is 0 whenever no code is latched. This covers the cycle after the fourth bit and the cycles after a slot start with no key pressed.
- R8: A `slot_start` that arrives while a group is still shifting discards the rest of that group and captures afresh.
- R9: Synchronous active-low reset `rst_n` clears the latch, so `ser_out` is 0 during reset and after it, until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_n | input | KEY_COUNT | Digit key contacts, low while pressed |
| slot_start | input | 1 | One-clock pulse at the first clock of the key digit slot |
| key_code | output | CODE_W | Binary value of the highest pressed key |
| key_any | output | 1 | High while any digit key is pressed |
| ser_out | output | 1 | Serial code, least-significant bit first, zero when idle |

## Verification
The hardest cases to reach from the ports are the ones where the key inputs or `slot_start` change in the middle of a 4-bit group: a key released or replaced after capture, and a second slot start arriving before the fourth bit. Directed sequences drive these changes at chosen negative edges between the capture edge and the fourth bit. They then reassemble the serial bits and compare them with the code that should have been latched. A reset asserted halfway through a group is handled the same way.

// File: rtl/keypad_digit_serializer.sv
module keypad_digit_serializer #(
  parameter int KEY_COUNT = 10,
  localparam int CODE_W = $clog2(KEY_COUNT),
  localparam int CNT_W = $clog2(CODE_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KEY_COUNT-1:0] key_n,
  input  logic                 slot_start,
  output logic [CODE_W-1:0]    key_code,
  output logic                 key_any,
  output logic                 ser_out
);

  logic [CODE_W-1:0] shreg;
  logic [CNT_W-1:0]  left;

  always_comb begin
    key_code = '0;
    for (int k = 0; k < KEY_COUNT; k++)
      if (!key_n[k]) key_code = CODE_W'(k);
  end

  assign key_any = ~&key_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (slot_start) begin
      shreg <= key_any ? key_code : '0;
      left  <= key_any ? CNT_W'(CODE_W) : '0;
    end else if (left != '0) begin
      shreg <= shreg >> 1;
      left  <= left - 1'b1;
    end
  end

  assign ser_out = (left != '0) & shreg[0];

  // R3
  idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_any |-> key_code == '0);

  // R2
  top_key_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_n[KEY_COUNT-1] |-> key_code == CODE_W'(KEY_COUNT - 1));

  // R5
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && key_any |=> ser_out == $past(key_code[0]));

  // R7
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start && !key_any |=> !ser_out);

  // R5
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, CODE_W) && $past(slot_start, CODE_W) && $past(key_any, CODE_W) &&
    !$past(slot_start, 3) && !$past(slot_start, 2) && !$past(slot_start, 1)
    |-> ser_out == $past(key_code[CODE_W-1], CODE_W));

endmodule

// File: tb/tb_keypad_digit_serializer.sv
module tb_keypad_digit_serializer;
  logic clk = 0;
  logic rst_n = 0;
  logic [9:0] key_n = '1;
  logic slot_start = 0;
  logic [3:0] key_code;
  logic key_any, ser_out;
  int checks = 0, errors = 0;
  logic [3:0] got;
  logic tail;

  keypad_digit_serializer dut (.clk(clk), .rst_n(rst_n), .key_n(key_n),
    .slot_start(slot_start), .key_code(key_code), .key_any(key_any), .ser_out(ser_out));

  always #4 clk = ~clk;

  // {key_n, expected code, expected any}
  localparam logic [14:0] VEC [16] = '{
    {10'h3FF, 4'd0, 1'b0}, {10'h3FE, 4'd0, 1'b1}, {10'h3FD, 4'd1, 1'b1},
    {10'h3FB, 4'd2, 1'b1}, {10'h3F7, 4'd3, 1'b1}, {10'h3EF, 4'd4, 1'b1},
    {10'h3DF, 4'd5, 1'b1}, {10'h3BF, 4'd6, 1'b1}, {10'h37F, 4'd7, 1'b1},
    {10'h2FF, 4'd8, 1'b1}, {10'h1FF, 4'd9, 1'b1}, {10'h3DB, 4'd5, 1'b1},
    {10'h1FE, 4'd9, 1'b1}, {10'h337, 4'd7, 1'b1}, {10'h000, 4'd9, 1'b1},
    {10'h2FD, 4'd8, 1'b1}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_slot(output logic [3:0] bits, output logic idle);
    @(negedge clk) slot_start = 1;
    @(negedge clk) slot_start = 0;
    bits[0] = ser_out;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk) bits[i] = ser_out;
    end
    @(negedge clk) idle = ser_out;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset holds ser_out low even with a key and slot start
    key_n = 10'h1FF;
    repeat (2) @(negedge clk);
    slot_start = 1;
    @(negedge clk) check("R9 in reset", ser_out, 0);
    slot_start = 0;
    rst_n = 1;
    @(negedge clk) check("R9 after reset", ser_out, 0);

    // R4: key held without slot start never drives the line
    key_n = 10'h37F;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ser_out !== 1'b0) check("R4 no capture without slot", ser_out, 0);
    end
    check("R4 no capture without slot", ser_out, 0);

    // R1 R2 R3 R5 R7: table walk
    foreach (VEC[v]) begin
      @(negedge clk) key_n = VEC[v][14:5];
      #1;
      check(VEC[v][0] ? "R1 R2 code" : "R3 idle code", key_code, VEC[v][4:1]);
      check("R3 any flag", key_any, VEC[v][0]);
      run_slot(got, tail);
      check(VEC[v][0] ? "R5 serial lsb first" : "R7 empty slot", got, VEC[v][4:1]);
      check("R7 line low after group", tail, 0);
    end

    // R6: key 6 captured, then changed and released mid-group
    @(negedge clk) key_n = ~10'h040;
    slot_start = 1;
    @(negedge clk) slot_start = 0;
    got[0] = ser_out;
    key_n = ~10'h200;
    @(negedge clk) got[1] = ser_out;
    key_n = '1;
    @(negedge clk) got[2] = ser_out;
    @(negedge clk) got[3] = ser_out;
    check("R6 latched code held", got, 6);
    @(negedge clk) check("R7 low after held group", ser_out, 0);

    // R8: key 5 group interrupted after two bits by capture of key 3
    key_n = ~10'h020;
    @(negedge clk) slot_start = 1;
    @(negedge clk) slot_start = 0;
    got[0] = ser_out;
    @(negedge clk) got[1] = ser_out;
    check("R8 first bits of key 5", got[1:0], 1);
    key_n = ~10'h008;
    slot_start = 1;
    @(negedge clk) slot_start = 0;
    got[0] = ser_out;
    for (int i = 1; i < 4; i++) begin
      @(negedge clk) got[i] = ser_out;
    end
    check("R8 recaptured code", got, 3);
    @(negedge clk) check("R8 R7 tail", ser_out, 0);

    // R9: reset in the middle of a group clears the line
    key_n = ~10'h080;
    @(negedge clk) slot_start = 1;
    @(negedge clk) slot_start = 0;
    check("R5 bit0 of key 7", ser_out, 1);
    rst_n = 0;
    @(negedge clk) check("R9 reset mid group", ser_out, 0);
    rst_n = 1;
    @(negedge clk) check("R9 stays low after reset", ser_out, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule